// File: doc/BRIEF.md
# PWM Event Action Qualifier

This block turns the events of an external time-base counter into the level of one PWM output pin. Each clock it looks at the counter value, the counter's direction and counting mode, the period value and the active values of two compare registers, A and B. From these it finds up to six events: the counter at zero, at period, at compare A while rising or falling, and at compare B while rising or falling.

A 16-bit control register holds one 2-bit action code per event: leave the pin alone, drive it low, drive it high, or invert it. Software reads and writes the register through a single-register port. When several events coincide, one action is applied, picked by a fixed priority. The pin is registered, resets low, and moves one clock after the event. A count-enable input marks the cycles in which the counter actually stepped, so a held counter value acts only once.

Top module: `pwm_aq_top`

## Requirements
- R1: The control register holds action fields at fixed bit positions: [1:0] zero event, [3:2] period event, [5:4] compare A rising, [7:6] compare A falling, [9:8] compare B rising, [11:10] compare B falling; reg_rdata shows the current register contents.
- R2: Every action field uses one code: 0 leaves the output as it is, 1 drives it low, 2 drives it high, 3 inverts the present level.
- R3: Bits [15:12] of the register always read 0, whatever is written to them.
- R4: Reset clears every field and drives pwm_out low, so after reset no event alters the output.
- R5: A compare event fires only when cnt_val equals that compare value; the rising field applies when the counter is incrementing and the falling field when it is decrementing (cnt_dir 1 = incrementing).
- R6: In up-down mode the counter at period is taken as decrementing and at zero as incrementing, whatever cnt_dir says, and compare matches at those values use that direction.
- R7: The zero event fires when cnt_val is 0; the period event fires when cnt_val equals prd_val.
- R8: When several events fire in one cycle, a single action is applied: the first event with a non-zero code in the order compare B, compare A, zero, period.
- R9: pwm_out is registered: it changes on the clock edge that samples the event, not before.
- R10: With cnt_en low no event is detected and pwm_out holds.
- R11: cnt_mode 0 counts up (always incrementing), 1 counts down (always decrementing), 2 or 3 selects up-down, where cnt_dir gives the direction away from zero and period.
- R12: A register write takes effect on the next clock; an event in the same cycle as the write uses the old field values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter stepped this cycle; gates event detection |
| cnt_val | input | CNT_W | Time-base counter value |
| cnt_dir | input | 1 | Counter direction in up-down mode, 1 = incrementing |
| cnt_mode | input | 2 | Counting mode: 0 up, 1 down, 2/3 up-down |
| prd_val | input | CNT_W | Period value |
| cmpa_val | input | CNT_W | Active compare A value |
| cmpb_val | input | CNT_W | Active compare B value |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read data |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Both pwm_out and reg_rdata are due on the first clock edge after their stimulus: an event presented with cnt_en high moves pwm_out at that edge, and a write shows in reg_rdata at that same edge. The bench drives inputs on the falling edge and samples one nanosecond after the following rising edge, and for the registered-output case it also samples just before that rising edge to confirm the old level still stands. The same-cycle write-plus-event case is checked at that edge against the old field, then one step later against the new one.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  localparam logic [1:0] MODE_UP   = 2'd0;
  localparam logic [1:0] MODE_DOWN = 2'd1;

  localparam int REG_W    = 16;
  localparam int FLD_W    = 2;
  localparam int NUM_EVT  = 6;
  localparam int USED_W   = NUM_EVT * FLD_W;
  localparam int NUM_SLOT = 4;

  // field index = bit position / 2
  localparam int F_ZERO = 0;
  localparam int F_PRD  = 1;
  localparam int F_AUP  = 2;
  localparam int F_ADN  = 3;
  localparam int F_BUP  = 4;
  localparam int F_BDN  = 5;

endpackage

// File: rtl/aq_ctrl_reg.sv
module aq_ctrl_reg
  import pwm_aq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic [REG_W-1:0]              wdata,
  output logic [REG_W-1:0]              rdata,
  output logic [NUM_EVT-1:0][FLD_W-1:0] fld
);
  logic [USED_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst)     reg_q <= '0;
    else if (wr) reg_q <= wdata[USED_W-1:0];
  end

  assign rdata = {{(REG_W-USED_W){1'b0}}, reg_q};

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_fld
    assign fld[i] = reg_q[i*FLD_W +: FLD_W];
  end
endmodule

// File: rtl/aq_event_detect.sv
module aq_event_detect
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] cmpb,
  output logic             is_up,
  output logic             hit_zero,
  output logic             hit_prd,
  output logic             hit_a,
  output logic             hit_b
);
  logic at_zero, at_prd;

  assign at_zero = (cnt == '0);
  assign at_prd  = (cnt == prd);

  always_comb begin
    if (mode == MODE_UP)        is_up = 1'b1;
    else if (mode == MODE_DOWN) is_up = 1'b0;
    else if (at_prd)            is_up = 1'b0;
    else if (at_zero)           is_up = 1'b1;
    else                        is_up = dir;
  end

  assign hit_zero = en && at_zero;
  assign hit_prd  = en && at_prd;
  assign hit_a    = en && (cnt == cmpa);
  assign hit_b    = en && (cnt == cmpb);
endmodule

// File: rtl/aq_action_sel.sv
module aq_action_sel
  import pwm_aq_pkg::*;
(
  input  logic [NUM_EVT-1:0][FLD_W-1:0] fld,
  input  logic                          is_up,
  input  logic                          hit_zero,
  input  logic                          hit_prd,
  input  logic                          hit_a,
  input  logic                          hit_b,
  output act_e                          act
);
  // slot 0 has highest priority
  logic [NUM_SLOT-1:0]            slot_hit;
  logic [NUM_SLOT-1:0][FLD_W-1:0] slot_act;

  assign slot_hit = {hit_prd, hit_zero, hit_a, hit_b};
  assign slot_act[0] = is_up ? fld[F_BUP] : fld[F_BDN];
  assign slot_act[1] = is_up ? fld[F_AUP] : fld[F_ADN];
  assign slot_act[2] = fld[F_ZERO];
  assign slot_act[3] = fld[F_PRD];

  always_comb begin
    act = ACT_NONE;
    for (int s = NUM_SLOT - 1; s >= 0; s--) begin
      if (slot_hit[s] && (slot_act[s] != ACT_NONE)) act = act_e'(slot_act[s]);
    end
  end
endmodule

// File: rtl/pwm_aq_top.sv
module pwm_aq_top
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_dir,
  input  logic [1:0]       cnt_mode,
  input  logic [CNT_W-1:0] prd_val,
  input  logic [CNT_W-1:0] cmpa_val,
  input  logic [CNT_W-1:0] cmpb_val,
  input  logic             reg_wr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             pwm_out
);
  logic [NUM_EVT-1:0][FLD_W-1:0] fld;
  logic is_up, hit_zero, hit_prd, hit_a, hit_b;
  act_e act;
  logic pwm_q;

  aq_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .fld(fld)
  );

  aq_event_detect #(.CNT_W(CNT_W)) u_det (
    .en(cnt_en), .cnt(cnt_val), .dir(cnt_dir), .mode(cnt_mode),
    .prd(prd_val), .cmpa(cmpa_val), .cmpb(cmpb_val),
    .is_up(is_up), .hit_zero(hit_zero), .hit_prd(hit_prd),
    .hit_a(hit_a), .hit_b(hit_b)
  );

  aq_action_sel u_sel (
    .fld(fld), .is_up(is_up), .hit_zero(hit_zero), .hit_prd(hit_prd),
    .hit_a(hit_a), .hit_b(hit_b), .act(act)
  );

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else begin
      case (act)
        ACT_LOW:    pwm_q <= 1'b0;
        ACT_HIGH:   pwm_q <= 1'b1;
        ACT_TOGGLE: pwm_q <= ~pwm_q;
        default:    pwm_q <= pwm_q;
      endcase
    end
  end

  assign pwm_out = pwm_q;
endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] prd_val,
  input logic [CNT_W-1:0] cmpa_val,
  input logic [CNT_W-1:0] cmpb_val,
  input logic             reg_wr,
  input logic [15:0]      reg_wdata,
  input logic [15:0]      reg_rdata,
  input logic             pwm_out
);
  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[15:12] == 4'd0);

  assert_reset_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pwm_out && reg_rdata == 16'd0));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> pwm_out == $past(pwm_out));

  assert_write_next_R12: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> reg_rdata == {4'd0, $past(reg_wdata[11:0])});

  assert_zero_set_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && cnt_val == '0 && prd_val != '0 && cmpa_val != '0 &&
     cmpb_val != '0 && reg_rdata[1:0] == 2'd2) |=> pwm_out);

  assert_prd_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && cnt_val == prd_val && cnt_val != '0 && cmpa_val != cnt_val &&
     cmpb_val != cnt_val && reg_rdata[3:2] == 2'd3) |=> pwm_out != $past(pwm_out));
endmodule

bind pwm_aq_top pwm_aq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pwm_aq_top_tb.sv
`timescale 1ns/1ps
module pwm_aq_top_tb;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cnt_en = 1'b0;
  logic [CNT_W-1:0] cnt_val = '0;
  logic             cnt_dir = 1'b1;
  logic [1:0]       cnt_mode = 2'd0;
  logic [CNT_W-1:0] prd_val = 16'd10;
  logic [CNT_W-1:0] cmpa_val = 16'd5;
  logic [CNT_W-1:0] cmpb_val = 16'd7;
  logic             reg_wr = 1'b0;
  logic [15:0]      reg_wdata = '0;
  logic [15:0]      reg_rdata;
  logic             pwm_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwm_aq_top #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_val(cnt_val), .cnt_dir(cnt_dir),
    .cnt_mode(cnt_mode), .prd_val(prd_val), .cmpa_val(cmpa_val), .cmpb_val(cmpb_val),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [CNT_W-1:0] c, input logic d, input logic en);
    @(negedge clk);
    cnt_val = c; cnt_dir = d; cnt_en = en;
    @(posedge clk); #1;
    cnt_en = 1'b0;
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk);
    cnt_en = 1'b0; reg_wr = 1'b1; reg_wdata = v;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R4 pwm after reset", {15'd0, pwm_out}, 16'd0);
    chk("R4 reg after reset", reg_rdata, 16'd0);
    step(16'd0, 1'b1, 1'b1); step(16'd5, 1'b1, 1'b1);
    step(16'd7, 1'b1, 1'b1); step(16'd10, 1'b1, 1'b1);
    chk("R4 events inert after reset", {15'd0, pwm_out}, 16'd0);
  endtask

  task automatic t_reserved;
    wr(16'hFFFF);
    chk("R3 R1 reserved bits read zero", reg_rdata, 16'h0FFF);
  endtask

  task automatic t_zero_prd;
    cnt_mode = 2'd0;
    wr(16'h0006);               // zero=high, period=low
    @(negedge clk);
    cnt_val = 16'd0; cnt_dir = 1'b1; cnt_en = 1'b1;
    #1 chk("R9 no change before edge", {15'd0, pwm_out}, 16'd0);
    @(posedge clk); #1; cnt_en = 1'b0;
    chk("R7 R2 zero sets high", {15'd0, pwm_out}, 16'd1);
    step(16'd3, 1'b1, 1'b1);
    chk("R7 no event mid count", {15'd0, pwm_out}, 16'd1);
    step(16'd10, 1'b1, 1'b1);
    chk("R7 R2 period drives low", {15'd0, pwm_out}, 16'd0);
  endtask

  task automatic t_dir;
    cnt_mode = 2'd2;
    wr(16'h0660);               // A up high, A down low, B up high, B down low
    step(16'd5, 1'b1, 1'b1);
    chk("R5 compare A rising", {15'd0, pwm_out}, 16'd1);
    step(16'd5, 1'b0, 1'b1);
    chk("R5 compare A falling", {15'd0, pwm_out}, 16'd0);
    step(16'd7, 1'b1, 1'b1);
    chk("R5 compare B rising", {15'd0, pwm_out}, 16'd1);
    step(16'd7, 1'b0, 1'b1);
    chk("R5 compare B falling", {15'd0, pwm_out}, 16'd0);
  endtask

  task automatic t_updown_rule;
    cmpa_val = 16'd10; cmpb_val = 16'd0;
    wr(16'h0960);               // A up high, A down low, B up low, B down high
    cnt_mode = 2'd0;
    step(16'd10, 1'b1, 1'b1);
    chk("R11 up mode at period rises", {15'd0, pwm_out}, 16'd1);
    cnt_mode = 2'd2;
    step(16'd10, 1'b1, 1'b1);
    chk("R6 period counts as falling", {15'd0, pwm_out}, 16'd0);
    step(16'd0, 1'b0, 1'b1);
    chk("R6 zero counts as rising", {15'd0, pwm_out}, 16'd0);
  endtask

  task automatic t_priority;
    cnt_mode = 2'd0; cmpa_val = 16'd0; cmpb_val = 16'd0;
    wr(16'h0031);               // A up toggle, zero low
    step(16'd0, 1'b1, 1'b1);
    chk("R8 compare A over zero", {15'd0, pwm_out}, 16'd1);
    wr(16'h0231);               // B up high added
    step(16'd0, 1'b1, 1'b1);
    chk("R8 compare B over compare A", {15'd0, pwm_out}, 16'd1);
    wr(16'h0001);               // compares none, zero low
    step(16'd0, 1'b1, 1'b1);
    chk("R8 none codes fall through", {15'd0, pwm_out}, 16'd0);
  endtask

  task automatic t_hold;
    cnt_mode = 2'd0; cmpa_val = 16'd5; cmpb_val = 16'd7;
    wr(16'h0030);               // A up toggle
    step(16'd5, 1'b1, 1'b1);
    chk("R2 toggle low to high", {15'd0, pwm_out}, 16'd1);
    step(16'd5, 1'b1, 1'b0);
    step(16'd5, 1'b1, 1'b0);
    chk("R10 held counter no retrigger", {15'd0, pwm_out}, 16'd1);
    step(16'd5, 1'b1, 1'b1);
    chk("R2 toggle high to low", {15'd0, pwm_out}, 16'd0);
  endtask

  task automatic t_mode;
    wr(16'h0090);               // A up low, A down high
    cnt_mode = 2'd1;
    step(16'd5, 1'b1, 1'b1);
    chk("R11 down mode ignores dir", {15'd0, pwm_out}, 16'd1);
    cnt_mode = 2'd0;
    step(16'd5, 1'b0, 1'b1);
    chk("R11 up mode ignores dir", {15'd0, pwm_out}, 16'd0);
  endtask

  task automatic t_write_same;
    cnt_mode = 2'd0;
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 16'h0020;   // A up high; old A up low
    cnt_val = 16'd5; cnt_dir = 1'b1; cnt_en = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; cnt_en = 1'b0;
    chk("R12 same-cycle event uses old field", {15'd0, pwm_out}, 16'd0);
    chk("R12 R1 write visible next clock", reg_rdata, 16'h0020);
    step(16'd5, 1'b1, 1'b1);
    chk("R12 new field applies afterwards", {15'd0, pwm_out}, 16'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_reserved();
    t_zero_prd();
    t_dir();
    t_updown_rule();
    t_priority();
    t_hold();
    t_mode();
    t_write_same();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule